// File: doc/BRIEF.md
# Display Line Interrupt Generator

This block produces the interrupt request for an on-screen display engine. It watches three things: the vertical sync input, a strobe that marks the end of each scanline, and a flag that says whether the current scanline is the last one of a character row. From these it keeps a saturating count of completed display rows. Software picks one of two interrupt sources. The first is the falling edge of vertical sync. The second is a point in the row count: either the moment the counter is cleared, or the end of the last scanline of a chosen row.

The interrupt leaves the block as a single-cycle pulse on `irq_pulse`. All of the block's pins are plain control and status pins; no data stream passes through it, so it has no valid/ready handshake. Configuration is a single 5-bit write port. A write changes the behaviour from the next clock cycle onward, and it does not wait for a frame boundary.

Top module: `osd_line_irq`

## Requirements
- R1: After reset, `irq_pulse` is 0. The source select and the line selection are both 0, and the row counter is 0.
- R2: A write to `cfg_wdata` stores bit 4 as the source select and bits 3:0 as the line selection. With source select 1, an interrupt comes only from a falling edge of vertical sync. With source select 0, it comes only from row-counter events.
- R3: `vsync_in` passes through a two-flop synchronizer before the edge detector. A falling edge on `vsync_in` that is first sampled at clock edge k gives `irq_pulse` high after edge k+2. A rising edge gives nothing.
- R4: The row counter clears on a synchronized vertical sync fall and on a rising edge of `line_clr`. It increments when `scan_end` and `row_last` are both high in the same cycle. `scan_end` alone does not change it.
- R5: With source select 0 and line selection 0, every counter clear (from `line_clr` or from vertical sync) produces one pulse. For `line_clr`, the pulse is high in the cycle after the clock edge that samples the rising edge.
- R6: With source select 0 and line selection N from 1 to 15, a pulse appears in the cycle after the end-of-row strobe that completes display row N, which is the strobe that takes the counter from N-1 to N.
- R7: The counter saturates at 15. A further end-of-row strobe neither changes it nor raises an interrupt.
- R8: A configuration write applies from the cycle after its clock edge.
- R9: `irq_pulse` lasts one cycle for each event. If `line_clr` is held high for several cycles, the block gives one pulse.
- R10: When a clear and an end-of-row strobe arrive in the same cycle, the clear wins. The counter goes to 0, and no row-match interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_in | input | 1 | Vertical sync, asynchronous to `clk` |
| scan_end | input | 1 | One-cycle strobe at the end of each scanline |
| row_last | input | 1 | High while the current scanline is the last of its row |
| line_clr | input | 1 | Row counter clear request; acts on its rising edge |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 5 | Bit 4 is the source select, bits 3:0 the line selection |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The embedded assertions check the following on every cycle: the counter clears after any clear event, steps by exactly one on an end-of-row strobe below 15, and holds at 15. They also check that a configuration write lands, that a synchronized falling edge lasts a single cycle, and that the selected vertical sync or clear events always produce a pulse. Other properties span many cycles or depend on what software did earlier, so only the bench's scenarios can show them. These are the exact pulse latency through the synchronizer, the row-N match after a sequence of strobes, saturation after fifteen rows, the single pulse for a long `line_clr`, and the clear-over-increment priority.

// File: rtl/osd_irq_pkg.sv
package osd_irq_pkg;
  localparam int LINE_W = 4;
  localparam int CFG_W  = LINE_W + 1;

  typedef logic [LINE_W-1:0] line_t;

  typedef enum logic {
    SRC_LINE  = 1'b0,
    SRC_VSYNC = 1'b1
  } src_e;

  typedef struct packed {
    src_e  src;
    line_t line;
  } irq_cfg_t;
endpackage

// File: rtl/osd_vsync_edge.sv
module osd_vsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_in,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= vsync_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], vsync_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign fall = last_q & ~sync_q[STAGES-1];

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/osd_row_counter.sv
module osd_row_counter
  import osd_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_evt,
  input  logic  row_done,
  output line_t cnt
);
  localparam line_t CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (clr_evt)                    cnt <= '0;
    else if (row_done && cnt != CNT_MAX) cnt <= cnt + line_t'(1);
  end

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> cnt == '0);
  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_done && !clr_evt && cnt != CNT_MAX) |=> cnt == $past(cnt) + line_t'(1));
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr_evt) |=> cnt == CNT_MAX);
endmodule

// File: rtl/osd_irq_match.sv
module osd_irq_match
  import osd_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_cfg_t cfg,
  input  logic     vfall,
  input  logic     clr_evt,
  input  logic     row_done,
  input  line_t    cnt,
  output logic     irq
);
  logic hit;

  always_comb begin
    if (cfg.src == SRC_VSYNC)  hit = vfall;
    else if (cfg.line == '0)   hit = clr_evt;
    else                       hit = row_done && !clr_evt && (cnt == cfg.line - line_t'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit;
  end

  // R2
  vsync_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vfall && cfg.src == SRC_VSYNC) |=> irq);
  // R5
  clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && cfg.src == SRC_LINE && cfg.line == '0) |=> irq);
endmodule

// File: rtl/osd_line_irq.sv
module osd_line_irq
  import osd_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_in,
  input  logic             scan_end,
  input  logic             row_last,
  input  logic             line_clr,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             irq_pulse
);
  irq_cfg_t cfg_q;
  logic     clr_in_q;
  logic     vfall;
  logic     clr_evt;
  logic     row_done;
  line_t    cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{src: SRC_LINE, line: '0};
      clr_in_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= irq_cfg_t'(cfg_wdata);
      clr_in_q <= line_clr;
    end
  end

  assign clr_evt  = (line_clr & ~clr_in_q) | vfall;
  assign row_done = scan_end & row_last;

  osd_vsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsync_in (vsync_in),
    .fall     (vfall)
  );

  osd_row_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_evt  (clr_evt),
    .row_done (row_done),
    .cnt      (cnt)
  );

  osd_irq_match u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_q),
    .vfall    (vfall),
    .clr_evt  (clr_evt),
    .row_done (row_done),
    .cnt      (cnt),
    .irq      (irq_pulse)
  );

  // R8
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == irq_cfg_t'($past(cfg_wdata)));
endmodule

// File: tb/sim_osd_line_irq.sv
module sim_osd_line_irq;
  localparam int CLK_PERIOD = 10;
  localparam int A_ROW = 1, A_SCAN = 2, A_CLR = 3, A_VS = 4, A_BOTH = 5;
  localparam int NV = 11;
  // {src, line, action, expected pulse count}
  localparam logic [9:0] VEC [0:NV-1] = '{
    {1'b0, 4'd0, 3'd3, 2'd1},  // R5 clear fires with line 0
    {1'b0, 4'd2, 3'd1, 2'd0},  // R6 row 1 done, line 2
    {1'b0, 4'd2, 3'd2, 2'd0},  // R4 scan_end alone
    {1'b0, 4'd2, 3'd1, 2'd1},  // R6 row 2 done
    {1'b0, 4'd2, 3'd1, 2'd0},  // R6 row 3 done
    {1'b0, 4'd0, 3'd4, 2'd1},  // R5 vsync clear with line 0
    {1'b1, 4'd0, 3'd4, 2'd1},  // R2 vsync source
    {1'b1, 4'd1, 3'd1, 2'd0},  // R2 row ignored on vsync source
    {1'b1, 4'd0, 3'd3, 2'd0},  // R2 clear ignored on vsync source
    {1'b0, 4'd1, 3'd1, 2'd1},  // R4 row 1 after clear
    {1'b0, 4'd3, 3'd4, 2'd0}   // R4 vsync clears, line 3 silent
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic vsync_in = 1'b1, scan_end = 1'b0, row_last = 1'b0, line_clr = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic irq_pulse;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_line_irq u0 (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .scan_end(scan_end),
    .row_last(row_last), .line_clr(line_clr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .irq_pulse(irq_pulse)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic src, input logic [3:0] line);
    cfg_we = 1'b1; cfg_wdata = {src, line};
    tick;
    cfg_we = 1'b0;
  endtask

  task automatic act(input int kind, input int hold, output int cnt, output int first);
    cnt = 0; first = -1;
    case (kind)
      A_ROW:  begin scan_end = 1'b1; row_last = 1'b1; end
      A_SCAN: scan_end = 1'b1;
      A_CLR:  line_clr = 1'b1;
      A_VS:   vsync_in = 1'b0;
      A_BOTH: begin line_clr = 1'b1; scan_end = 1'b1; row_last = 1'b1; end
      default: ;
    endcase
    for (int i = 0; i < 8; i++) begin
      tick;
      if (irq_pulse) begin
        if (first < 0) first = i;
        cnt++;
      end
      if (i == hold - 1) begin
        scan_end = 1'b0; row_last = 1'b0; line_clr = 1'b0;
      end
      if (i == 5) vsync_in = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, f, tot;
    repeat (3) tick;
    rst_n = 1'b1;
    repeat (3) tick;
    chk("R1 irq after reset", irq_pulse, 0);
    act(A_CLR, 1, n, f);
    chk("R1 default cfg fires on clear", n, 1);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][9], VEC[v][8:5]);
      act(int'(VEC[v][4:2]), 1, n, f);
      chk($sformatf("R2 R4 R5 R6 table vec %0d", v), n, int'(VEC[v][1:0]));
    end

    // R6 latency
    wr(1'b0, 4'd1);
    act(A_ROW, 1, n, f);
    chk("R6 row pulse cycle", f, 0);
    // R3 latency through synchronizer
    wr(1'b1, 4'd0);
    act(A_VS, 1, n, f);
    chk("R3 vsync pulse cycle", f, 2);
    chk("R3 single pulse, rise silent", n, 1);

    // R7 saturation
    wr(1'b0, 4'd15);
    tot = 0;
    for (int r = 0; r < 14; r++) begin act(A_ROW, 1, n, f); tot += n; end
    chk("R7 rows 1..14 silent", tot, 0);
    act(A_ROW, 1, n, f);
    chk("R7 row 15 fires", n, 1);
    tot = 0;
    for (int r = 0; r < 3; r++) begin act(A_ROW, 1, n, f); tot += n; end
    chk("R7 saturated rows silent", tot, 0);

    // R9 held clear
    wr(1'b0, 4'd0);
    act(A_CLR, 4, n, f);
    chk("R9 held clear pulse count", n, 1);
    chk("R5 clear pulse cycle", f, 0);

    // R10 priority
    wr(1'b0, 4'd1);
    act(A_BOTH, 1, n, f);
    chk("R10 clear+row silent", n, 0);
    act(A_ROW, 1, n, f);
    chk("R10 counter was cleared", n, 1);

    // R8 immediate cfg
    act(A_ROW, 1, n, f);
    chk("R8 row 2 on line 1 silent", n, 0);
    wr(1'b0, 4'd3);
    act(A_ROW, 1, n, f);
    chk("R8 new line takes effect", n, 1);

    // R1 reset mid-run
    rst_n = 1'b0; tick; tick; rst_n = 1'b1; tick;
    chk("R1 irq low after reset", irq_pulse, 0);
    act(A_ROW, 1, n, f);
    chk("R1 cfg cleared by reset", n, 0);
    wr(1'b0, 4'd2);
    act(A_ROW, 1, n, f);
    chk("R1 counter cleared by reset", n, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule